// File: doc/BRIEF.md
# Triggered DAC Data Register Controller

This block is the digital front end of an on-chip digital-to-analog converter. Software reaches it through a simple word-addressed register bus. A sample goes first into a pending (holding) stage. It drives the converter code only after it is copied into a separate output stage. The copy happens in one of two ways. In free-running mode a written sample goes to the output straight away. In triggered mode the copy happens on the rising edge of one selected timer output, so the converter is updated at a steady rate set by a timer.

A ready flag in the status register tells software whether the pending sample has already moved to the output. Software polls this flag, or takes an interrupt from it, before it writes the next sample. The timer outputs arrive as plain asynchronous inputs. Each one is synchronized and edge-detected inside the block. The converter resolution can be 8 bits or 10 bits. In 8-bit mode the upper code bits are held at zero.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset, dac_code is 0, irq is 0, and reads return 0 for the mode register (address 0), 1 for status (address 3) and 0 for the interrupt mask (address 6).
- R2: When mode bit 0 is 0 (free-running), a write to the holding register (address 1) changes dac_code on the same clock edge that accepts the write, and status bit 0 stays 1. Clearing mode bit 0 while a sample is pending copies that sample on the next clock edge.
- R3: When mode bit 0 is 1 (triggered), a copy happens only on a rising edge of the timer input whose index is in mode bits [3:1]. A rise of the input causes the copy on the third clock edge after the rise. A high level, a falling edge, or an edge on a non-selected input causes no copy.
- R4: In triggered mode, a write to the holding register clears status bit 0 on the accepting edge. The bit returns to 1 on the edge that copies the sample to the output.
- R5: A second write to the holding register before the trigger replaces the pending sample without any error indication. Only the latest sample reaches dac_code.
- R6: Mode bit 4 selects the resolution. When it is 0 (8-bit), only write data bits [7:0] are taken and dac_code bits [9:8] are 0. When it is 1 (10-bit), write data bits [9:0] are taken.
- R7: Writing 1 in bit 0 to address 4 sets interrupt mask bit 0, and writing 1 in bit 0 to address 5 clears it. Address 6 reads the mask. irq is high while mask bit 0 and status bit 0 are both 1.
- R8: If a holding-register write and a selected trigger edge take effect on the same clock edge, the old pending value is copied to dac_code, and the new value stays pending with status bit 0 at 0.
- R9: Address 2 reads back the current dac_code. Address 0 reads back the mode register value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_trig | input | 3 | Asynchronous timer outputs used as trigger sources |
| dac_code | output | 10 | Code driven to the converter |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong ready flag shows up on irq and in the status read within one cycle of the write or copy that should have set or cleared it. A wrong pending value stays hidden until the next selected trigger edge. When that edge comes, it shows on dac_code three cycles after the timer input rises. A scoreboard matches every change of dac_code against the queue of expected copies, so a missing, extra or early copy is reported at the first cycle it appears.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   // register word addresses
   localparam int unsigned REG_MODE  = 0;
   localparam int unsigned REG_HOLD  = 1;
   localparam int unsigned REG_CODE  = 2;
   localparam int unsigned REG_STAT  = 3;
   localparam int unsigned REG_IEN   = 4;
   localparam int unsigned REG_IDIS  = 5;
   localparam int unsigned REG_IMASK = 6;

   localparam int unsigned MODE_W    = 5;
   localparam int unsigned SRC_W     = 3;
   localparam int unsigned MAX_TRIG  = 1 << SRC_W;

   // mode register layout: [4] wide resolution, [3:1] trigger source, [0] trigger enable
   typedef struct packed {
      logic             wide;
      logic [SRC_W-1:0] src;
      logic             trig_en;
   } dac_mode_t;

endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
   parameter int unsigned N_TRIG = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TRIG-1:0] trig_async,
   output logic [N_TRIG-1:0] trig_rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dac_trig_sync: STAGES must be at least 2");
      end
      if (N_TRIG < 1) begin : g_bad_count
         $error("dac_trig_sync: N_TRIG must be at least 1");
      end
   endgenerate

   generate
      for (genvar t = 0; t < N_TRIG; t++) begin : g_lane
         logic [STAGES-1:0] chain;
         logic              last_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain  <= '0;
               last_q <= 1'b0;
            end else begin
               chain  <= {chain[STAGES-2:0], trig_async[t]};
               last_q <= chain[STAGES-1];
            end
         end

         assign trig_rise[t] = chain[STAGES-1] & ~last_q;

         AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            trig_rise[t] |=> !trig_rise[t]);  // R3
      end
   endgenerate

endmodule

// File: rtl/dac_regs.sv
module dac_regs
   import dacfe_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [CODE_W-1:0] code_q,
   input  logic              ready_q,
   output dac_mode_t         mode_q,
   output logic              hold_wr,
   output logic              imask_q,
   output logic [BUS_W-1:0]  bus_rdata
);

   localparam int unsigned MAX_ADDR = REG_IMASK;

   generate
      if (BUS_W < CODE_W || BUS_W < MODE_W) begin : g_bad_bus
         $error("dac_regs: BUS_W too narrow for the registers");
      end
      if ((1 << ADDR_W) <= MAX_ADDR) begin : g_bad_addr
         $error("dac_regs: ADDR_W cannot reach every register");
      end
   endgenerate

   logic wr_mode, wr_ien, wr_idis;

   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(REG_MODE));
   assign hold_wr = bus_wr && (bus_addr == ADDR_W'(REG_HOLD));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(REG_IEN));
   assign wr_idis = bus_wr && (bus_addr == ADDR_W'(REG_IDIS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode) begin
         mode_q <= dac_mode_t'(bus_wdata[MODE_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask_q <= 1'b0;
      end else if (wr_ien && bus_wdata[0]) begin
         imask_q <= 1'b1;
      end else if (wr_idis && bus_wdata[0]) begin
         imask_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_MODE):  bus_rdata[MODE_W-1:0] = mode_q;
         ADDR_W'(REG_CODE):  bus_rdata[CODE_W-1:0] = code_q;
         ADDR_W'(REG_STAT):  bus_rdata[0]          = ready_q;
         ADDR_W'(REG_IMASK): bus_rdata[0]          = imask_q;
         default:            bus_rdata             = '0;
      endcase
   end

   AST_IEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && bus_wdata[0]) |=> imask_q);  // R7
   AST_IDIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_idis && bus_wdata[0]) |=> !imask_q);  // R7

endmodule

// File: rtl/dac_data_path.sv
module dac_data_path
   import dacfe_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned CODE_W = 10,
   parameter int unsigned LOW_W  = 8,
   parameter int unsigned N_TRIG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dac_mode_t         mode_q,
   input  logic              hold_wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [N_TRIG-1:0] trig_rise,
   output logic [CODE_W-1:0] code_q,
   output logic              ready_q
);

   localparam int unsigned PAD_W = CODE_W - LOW_W;

   generate
      if (LOW_W >= CODE_W) begin : g_bad_res
         $error("dac_data_path: LOW_W must be below CODE_W");
      end
      if (N_TRIG > MAX_TRIG) begin : g_bad_trig
         $error("dac_data_path: more triggers than the source field selects");
      end
   endgenerate

   logic [CODE_W-1:0] hold_q;
   logic [CODE_W-1:0] wr_val;
   logic [CODE_W-1:0] hold_out;
   logic              sel_rise;
   logic              copy;

   // value taken from the bus, narrowed in low resolution
   assign wr_val   = mode_q.wide ? wdata[CODE_W-1:0]
                                 : {{PAD_W{1'b0}}, wdata[LOW_W-1:0]};
   assign hold_out = mode_q.wide ? hold_q : {{PAD_W{1'b0}}, hold_q[LOW_W-1:0]};

   always_comb begin
      sel_rise = 1'b0;
      for (int i = 0; i < N_TRIG; i++) begin
         if (mode_q.src == SRC_W'(i)) sel_rise = trig_rise[i];
      end
   end

   assign copy = mode_q.trig_en ? sel_rise : !ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         code_q  <= '0;
         ready_q <= 1'b1;
      end else if (hold_wr && !mode_q.trig_en) begin
         hold_q  <= wr_val;
         code_q  <= wr_val;
         ready_q <= 1'b1;
      end else begin
         if (copy) begin
            code_q  <= hold_out;
            ready_q <= 1'b1;
         end
         if (hold_wr) begin
            hold_q  <= wr_val;
            ready_q <= 1'b0;
         end
      end
   end

   AST_FREE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_wr && !mode_q.trig_en) |=> (ready_q && code_q == $past(wr_val)));  // R2
   AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_wr && mode_q.trig_en) |=> !ready_q);  // R4
   AST_NO_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.trig_en && !sel_rise && !hold_wr) |=> $stable(code_q));  // R3
   AST_LOW_RES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (copy && !mode_q.wide && !hold_wr) |=> (code_q[CODE_W-1:LOW_W] == '0));  // R6
   AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_wr && mode_q.trig_en && sel_rise) |=> (!ready_q && code_q == $past(hold_out)));  // R8

endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
   import dacfe_pkg::*;
#(
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned CODE_W      = 10,
   parameter int unsigned LOW_W       = 8,
   parameter int unsigned N_TRIG      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [N_TRIG-1:0] tmr_trig,
   output logic [CODE_W-1:0] dac_code,
   output logic              irq
);

   dac_mode_t         mode_q;
   logic              hold_wr;
   logic              imask_q;
   logic              ready_q;
   logic [N_TRIG-1:0] trig_rise;

   dac_trig_sync #(
      .N_TRIG (N_TRIG),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (tmr_trig),
      .trig_rise  (trig_rise)
   );

   dac_regs #(
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .code_q    (dac_code),
      .ready_q   (ready_q),
      .mode_q    (mode_q),
      .hold_wr   (hold_wr),
      .imask_q   (imask_q),
      .bus_rdata (bus_rdata)
   );

   dac_data_path #(
      .BUS_W  (BUS_W),
      .CODE_W (CODE_W),
      .LOW_W  (LOW_W),
      .N_TRIG (N_TRIG)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_q    (mode_q),
      .hold_wr   (hold_wr),
      .wdata     (bus_wdata),
      .trig_rise (trig_rise),
      .code_q    (dac_code),
      .ready_q   (ready_q)
   );

   assign irq = imask_q & ready_q;

   AST_IRQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_wr && mode_q.trig_en && !trig_rise[mode_q.src % N_TRIG]) |=> !irq);  // R7

endmodule

// File: tb/dac_trig_ctrl_tb.sv
module dac_trig_ctrl_tb;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned CODE_W = 10;
   localparam int unsigned N_TRIG = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic [N_TRIG-1:0] tmr_trig = '0;
   logic [CODE_W-1:0] dac_code;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   logic [CODE_W-1:0] exp_q[$];
   logic [CODE_W-1:0] prev_code;

   always #2.5 clk = ~clk;

   dac_trig_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tmr_trig  (tmr_trig),
      .dac_code  (dac_code),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned addr, input logic [31:0] data);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = ADDR_W'(addr);
      bus_wdata = data;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int unsigned addr, output logic [31:0] data);
      @(negedge clk);
      bus_addr = ADDR_W'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // scoreboard monitor: every change of dac_code must match the next expected copy
   always @(negedge clk) begin
      if (mon_on && dac_code !== prev_code) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R3: actual %0h expected no change", dac_code);
         end else begin
            chk("R3 scoreboard", 32'(dac_code), 32'(exp_q.pop_front()));
         end
         prev_code = dac_code;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 code", 32'(dac_code), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      rd(0, d); chk("R1 mode", d, 32'h0);
      rd(3, d); chk("R1 status", d, 32'h1);
      rd(6, d); chk("R1 mask", d, 32'h0);
      prev_code = dac_code;
      mon_on = 1'b1;

      // R2 free-running, 10-bit
      wr(0, 32'h10);
      exp_q.push_back(10'h2C3);
      wr(1, 32'hFFFF_F2C3);
      chk("R2 code", 32'(dac_code), 32'h2C3);
      rd(3, d); chk("R2 status", d, 32'h1);

      // R6 8-bit mode
      wr(0, 32'h00);
      exp_q.push_back(10'h0A5);
      wr(1, 32'h3A5);
      chk("R6 low res code", 32'(dac_code), 32'h0A5);

      // R3 / R4 triggered, source 1, 10-bit
      wr(0, 32'h13);
      rd(0, d); chk("R9 mode readback", d, 32'h13);
      wr(1, 32'h155);
      rd(3, d); chk("R4 pending status", d, 32'h0);
      tmr_trig[0] = 1'b1;
      idle(6);
      tmr_trig[0] = 1'b0;
      idle(4);
      chk("R3 unselected source", 32'(dac_code), 32'h0A5);
      exp_q.push_back(10'h155);
      tmr_trig[1] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R3 not before third edge", 32'(dac_code), 32'h0A5);
      @(negedge clk);
      chk("R3 copy on third edge", 32'(dac_code), 32'h155);
      rd(3, d); chk("R4 status after copy", d, 32'h1);
      idle(5);
      tmr_trig[1] = 1'b0;
      idle(5);
      chk("R3 level and fall ignored", 32'(dac_code), 32'h155);

      // R5 overwrite of pending sample
      wr(1, 32'h0F0);
      wr(1, 32'h30F);
      rd(3, d); chk("R5 pending status", d, 32'h0);
      exp_q.push_back(10'h30F);
      tmr_trig[1] = 1'b1;
      idle(5);
      chk("R5 latest sample", 32'(dac_code), 32'h30F);
      tmr_trig[1] = 1'b0;
      idle(4);

      // R8 write and trigger on the same edge
      wr(1, 32'h111);
      exp_q.push_back(10'h111);
      @(negedge clk);
      tmr_trig[1] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h222;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R8 old value copied", 32'(dac_code), 32'h111);
      rd(3, d); chk("R8 new value pending", d, 32'h0);
      tmr_trig[1] = 1'b0;
      idle(4);
      exp_q.push_back(10'h222);
      tmr_trig[1] = 1'b1;
      idle(5);
      chk("R8 second copy", 32'(dac_code), 32'h222);
      tmr_trig[1] = 1'b0;
      idle(4);

      // R7 interrupt mask and request
      wr(4, 32'h1);
      rd(6, d); chk("R7 mask set", d, 32'h1);
      chk("R7 irq when ready", 32'(irq), 32'h1);
      wr(1, 32'h033);
      chk("R7 irq low while pending", 32'(irq), 32'h0);
      exp_q.push_back(10'h033);
      tmr_trig[1] = 1'b1;
      idle(5);
      chk("R7 irq after copy", 32'(irq), 32'h1);
      tmr_trig[1] = 1'b0;
      wr(5, 32'h1);
      rd(6, d); chk("R7 mask cleared", d, 32'h0);
      chk("R7 irq masked", 32'(irq), 32'h0);
      idle(4);

      // R2 leaving triggered mode flushes the pending sample
      wr(1, 32'h3C3);
      exp_q.push_back(10'h3C3);
      wr(0, 32'h10);
      @(negedge clk);
      chk("R2 flush on mode change", 32'(dac_code), 32'h3C3);
      rd(3, d); chk("R2 status after flush", d, 32'h1);

      // R9 output register readback
      rd(2, d); chk("R9 code readback", d, 32'h3C3);

      idle(3);
      chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule